// File: doc/BRIEF.md
# SPI Receive Sample-Delay Selector

This block is the receive-capture stage of an SPI master. It moves the point at which the incoming serial data line is latched, so that the design can cope with the round-trip delay seen at high bus rates. The clock generator supplies two one-cycle strobes in the module clock domain. The capture strobe marks the nominal sampling edge of SCK. The launch strobe marks the opposite edge, half an SCK period later. Two control bits in a transfer-control register slice select one of three sampling points: the nominal edge, half an SCK period late, or one full SCK period late.

Every bit that is taken is presented on a one-bit output with a valid strobe. The bits are also packed, most significant bit first, into a word with its own completion strobe. The data line is first resynchronised to the module clock by a two-flop chain, and the sampling logic reads it only after that chain. In full-period mode the last bit of a word has no later capture edge to wait for. The block therefore times that bit with the period it measured between the first two capture strobes of the word. Mode writes made while a transfer is in progress are held back and applied once the transfer has ended.

Top module: `spi_rxd_sampler`

## Requirements
- R1: After reset the control bits read as zero, which selects half-period mode, and `rx_bit_vld` and `rx_word_vld` are low.
- R2: A control write made while `xfer_busy` is low takes effect at the same clock edge. `ctl_rdata` returns bit 13 (direct) and bit 11 (full lag) of the written value, and every other bit reads zero.
- R3: A control write made while `xfer_busy` is high does not change the mode or `ctl_rdata`. The held value becomes active at the first clock edge at which `xfer_busy` is low.
- R4: The value taken at a sampling edge is the `miso` level that was present two module-clock edges earlier (two-flop synchroniser).
- R5: Direct mode (bit13=1, bit11=0) samples at the clock edge of each of the first WORD_W capture strobes of a transfer.
- R6: Half-period mode (bit13=0, bit11=0) samples at the first launch strobe that follows each capture strobe. A launch strobe with no capture strobe still waiting takes nothing.
- R7: Full-period mode (bit13=0, bit11=1) samples each bit at the next capture strobe. The last bit of a word is sampled when the number of edges since its capture strobe equals the number of edges between the first two capture strobes.
- R8: The reserved setting (bit13=1, bit11=1) samples exactly as direct mode does.
- R9: Each sample raises `rx_bit_vld` for one cycle. Together with the WORD_W-th sample, `rx_word_vld` pulses for one cycle, and `rx_word` holds the bits with the first sampled bit in the most significant position.
- R10: While `xfer_busy` is low nothing is sampled, and any partly assembled word and any pending sample are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_busy | input | 1 | High while a transfer is in progress |
| ctl_we | input | 1 | Write strobe for the control slice |
| ctl_wdata | input | CTL_W | Write data; bits 13 and 11 are used |
| ctl_rdata | output | CTL_W | Active control bits, all other bits zero |
| cap_stb | input | 1 | Nominal capture-edge strobe of SCK |
| lch_stb | input | 1 | Opposite-edge (launch) strobe of SCK |
| miso | input | 1 | Raw serial input pin |
| rx_bit | output | 1 | Last sampled bit |
| rx_bit_vld | output | 1 | One-cycle strobe for `rx_bit` |
| rx_word | output | WORD_W | Last completed word, first bit as MSB |
| rx_word_vld | output | 1 | One-cycle strobe for `rx_word` |

## Verification
The bench drives `miso` from a pattern that changes on every module clock. A sample taken at the wrong edge, or one that ignores the synchroniser depth, therefore returns a different bit and lands on a different edge number from the one expected. The last bit in full-period mode is targeted directly: a design that waits for a capture strobe that never comes would deliver only WORD_W-1 bits and never complete the word. A control write made during a transfer is checked on the readback port before and after `xfer_busy` falls, which catches a design that applies it at once. The remaining corner cases are these: a transfer aborted part-way through, which a design that keeps stale bits would shift into the next word; launch strobes that arrive with no capture pending; and the reserved setting, which a naive decode would treat as full-period mode.

// File: rtl/spi_rxd_pkg.sv
package spi_rxd_pkg;
    typedef enum logic [1:0] {
        SMP_EDGE = 2'd0,
        SMP_HALF = 2'd1,
        SMP_FULL = 2'd2
    } smp_mode_e;
endpackage

// File: rtl/spi_rxd_ctl.sv
// Control slice: two mode bits, writes during a transfer are staged.
module spi_rxd_ctl
    import spi_rxd_pkg::*;
#(
    parameter int CTL_W      = 32,
    parameter int POS_DIRECT = 13,
    parameter int POS_FULL   = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_busy,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] rd_data,
    output smp_mode_e        mode
);
    typedef struct packed {
        logic direct;
        logic full;
        logic stg_vld;
        logic stg_direct;
        logic stg_full;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (!xfer_busy) begin
                st_d.direct  = wr_data[POS_DIRECT];
                st_d.full    = wr_data[POS_FULL];
                st_d.stg_vld = 1'b0;
            end else begin
                st_d.stg_direct = wr_data[POS_DIRECT];
                st_d.stg_full   = wr_data[POS_FULL];
                st_d.stg_vld    = 1'b1;
            end
        end else if (!xfer_busy && st_q.stg_vld) begin
            st_d.direct  = st_q.stg_direct;
            st_d.full    = st_q.stg_full;
            st_d.stg_vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data             = '0;
        rd_data[POS_DIRECT] = st_q.direct;
        rd_data[POS_FULL]   = st_q.full;
        if (st_q.direct)    mode = SMP_EDGE;   // reserved 1/1 folds here (R8)
        else if (st_q.full) mode = SMP_FULL;
        else                mode = SMP_HALF;
    end

    // R3: active bits never move across an edge that saw a busy transfer
    p_hold_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xfer_busy) |-> $stable({st_q.direct, st_q.full}));
endmodule

// File: rtl/spi_rxd_sync.sv
// Multi-flop resynchroniser for the serial input.
module spi_rxd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/spi_rxd_pick.sv
// Sampling-point selection: direct, half-period or full-period late.
module spi_rxd_pick
    import spi_rxd_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      xfer_busy,
    input  smp_mode_e mode,
    input  logic      cap_stb,
    input  logic      lch_stb,
    output logic      smp_now
);
    localparam int CAPW = $clog2(WORD_W + 1);

    typedef struct packed {
        logic             pend;
        logic [CAPW-1:0]  cap_cnt;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] period;
    } pick_st_t;

    pick_st_t st_d, st_q;
    logic     take;
    logic     hit;

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        take = 1'b0;
        if (!xfer_busy) begin
            st_d = '0;
        end else begin
            if (st_q.cnt != '1) st_d.cnt = st_q.cnt + 1'b1;
            take = cap_stb && (st_q.cap_cnt < CAPW'(WORD_W));
            if (take) begin
                st_d.cnt     = CNT_W'(1);
                st_d.cap_cnt = st_q.cap_cnt + 1'b1;
                if (st_q.cap_cnt == CAPW'(1)) st_d.period = st_q.cnt;
            end
            case (mode)
                SMP_EDGE: hit = take;
                SMP_HALF: begin
                    hit = lch_stb && st_q.pend;
                    if (hit)  st_d.pend = 1'b0;
                    if (take) st_d.pend = 1'b1;
                end
                default: begin
                    hit = st_q.pend && (take ||
                          (st_q.cap_cnt == CAPW'(WORD_W) && st_q.cnt == st_q.period));
                    if (hit)  st_d.pend = 1'b0;
                    if (take) st_d.pend = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp_now = hit;

    // R7: in full-period mode the first capture of a word never samples
    p_full_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && mode == SMP_FULL && cap_stb && st_q.cap_cnt == '0) |-> !smp_now);
endmodule

// File: rtl/spi_rxd_shift.sv
// Bit register and MSB-first word assembly.
module spi_rxd_shift #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_busy,
    input  logic              smp_now,
    input  logic              din,
    output logic              bit_q,
    output logic              bit_vld_q,
    output logic [WORD_W-1:0] word_q,
    output logic              word_vld_q
);
    localparam int BCW = $clog2(WORD_W);

    typedef struct packed {
        logic              bitv;
        logic              bit_vld;
        logic [WORD_W-1:0] sh;
        logic [BCW-1:0]    bcnt;
        logic [WORD_W-1:0] word;
        logic              word_vld;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.bit_vld  = smp_now;
        st_d.word_vld = 1'b0;
        if (!xfer_busy) st_d.bcnt = '0;
        if (smp_now) begin
            st_d.bitv = din;
            st_d.sh   = {st_q.sh[WORD_W-2:0], din};
            if (st_q.bcnt == BCW'(WORD_W - 1)) begin
                st_d.word     = {st_q.sh[WORD_W-2:0], din};
                st_d.word_vld = 1'b1;
                st_d.bcnt     = '0;
            end else begin
                st_d.bcnt = st_q.bcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_q      = st_q.bitv;
    assign bit_vld_q  = st_q.bit_vld;
    assign word_q     = st_q.word;
    assign word_vld_q = st_q.word_vld;

    // R9: a word completes only together with a sampled bit
    p_word_with_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_q |-> bit_vld_q);
endmodule

// File: rtl/spi_rxd_sampler.sv
module spi_rxd_sampler
    import spi_rxd_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int CNT_W       = 8,
    parameter int CTL_W       = 32,
    parameter int POS_DIRECT  = 13,
    parameter int POS_FULL    = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_busy,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic              cap_stb,
    input  logic              lch_stb,
    input  logic              miso,
    output logic              rx_bit,
    output logic              rx_bit_vld,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_word_vld
);
    smp_mode_e mode_w;
    logic      miso_s;
    logic      smp_now;

    spi_rxd_ctl #(.CTL_W(CTL_W), .POS_DIRECT(POS_DIRECT), .POS_FULL(POS_FULL)) u_ctl (
        .clk(clk), .rst_n(rst_n), .xfer_busy(xfer_busy),
        .wr_en(ctl_we), .wr_data(ctl_wdata), .rd_data(ctl_rdata), .mode(mode_w)
    );

    spi_rxd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(miso), .dout(miso_s)
    );

    spi_rxd_pick #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .xfer_busy(xfer_busy), .mode(mode_w),
        .cap_stb(cap_stb), .lch_stb(lch_stb), .smp_now(smp_now)
    );

    spi_rxd_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .xfer_busy(xfer_busy), .smp_now(smp_now),
        .din(miso_s), .bit_q(rx_bit), .bit_vld_q(rx_bit_vld),
        .word_q(rx_word), .word_vld_q(rx_word_vld)
    );

    // R5/R8: direct (and reserved) sampling only follows a capture strobe
    p_edge_on_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_bit_vld && $past(mode_w == SMP_EDGE)) |-> $past(cap_stb));

    // R6: half-period sampling only follows a launch strobe
    p_half_on_lch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_bit_vld && $past(mode_w == SMP_HALF)) |-> $past(lch_stb));

    // R10: nothing is sampled at an edge where no transfer was active
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(xfer_busy) |-> !rx_bit_vld);
endmodule

// File: tb/spi_rxd_sampler_bench.sv
module spi_rxd_sampler_bench;
    localparam int W = 8;
    localparam logic [63:0] PAT = 64'hD3A5_0F96_C71E_2B48;

    typedef struct packed {
        logic       d;
        logic       f;
        logic [7:0] p;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 1'b0, 8'd4}, '{1'b0, 1'b0, 8'd4}, '{1'b0, 1'b1, 8'd4}, '{1'b1, 1'b1, 8'd6},
        '{1'b0, 1'b0, 8'd8}, '{1'b0, 1'b1, 8'd6}, '{1'b1, 1'b0, 8'd10}, '{1'b0, 1'b1, 8'd10}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         xfer_busy = 1'b0;
    logic         ctl_we = 1'b0;
    logic [31:0]  ctl_wdata = '0;
    logic [31:0]  ctl_rdata;
    logic         cap_stb = 1'b0;
    logic         lch_stb = 1'b0;
    logic         miso = 1'b0;
    logic         rx_bit;
    logic         rx_bit_vld;
    logic [W-1:0] rx_word;
    logic         rx_word_vld;

    int checks = 0;
    int errors = 0;
    int g = 0;
    int nb = 0;
    int nw = 0;
    int got_e [16];
    logic got_b [16];
    int word_e = 0;
    logic [W-1:0] word_v = '0;

    always #5 clk = ~clk;

    spi_rxd_sampler u_spi_rxd_sampler (
        .clk(clk), .rst_n(rst_n), .xfer_busy(xfer_busy), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .cap_stb(cap_stb),
        .lch_stb(lch_stb), .miso(miso), .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld),
        .rx_word(rx_word), .rx_word_vld(rx_word_vld)
    );

    function automatic logic pat(int n);
        return PAT[6'(n % 64)];
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive inputs for the next edge, then observe that edge's result
    task automatic tick(input logic cp, input logic lc, input logic bz,
                        input logic we, input logic [31:0] wd);
        g++;
        cap_stb = cp; lch_stb = lc; xfer_busy = bz; ctl_we = we; ctl_wdata = wd;
        miso = pat(g);
        @(negedge clk);
        if (rx_bit_vld) begin
            if (nb < 16) begin got_e[nb] = g; got_b[nb] = rx_bit; end
            nb++;
        end
        if (rx_word_vld) begin word_e = g; word_v = rx_word; nw++; end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic set_mode(input logic d, input logic f);
        logic [31:0] v;
        v = '0; v[13] = d; v[11] = f;
        tick(1'b0, 1'b0, 1'b0, 1'b1, v);
        chk(ctl_rdata == v, "R2 mode readback", int'(ctl_rdata), int'(v));
    endtask

    task automatic run_word(input logic d, input logic f, input int p);
        int g0, len, off, ei;
        logic [W-1:0] ew;
        string tag;
        logic cp, lc;
        set_mode(d, f);
        nb = 0; nw = 0;
        g0 = g;
        len = 2 + W * p + 3;
        for (int k = 1; k <= len; k++) begin
            cp = (k >= 2) && ((k - 2) % p == 0) && ((k - 2) / p < W);
            lc = (k >= 2 + p/2) && ((k - 2 - p/2) % p == 0) && ((k - 2 - p/2) / p < W);
            tick(cp, lc, 1'b1, 1'b0, '0);
        end
        idle(2);
        if (d && f)  begin off = 0;     tag = "R8"; end
        else if (d)  begin off = 0;     tag = "R5"; end
        else if (f)  begin off = p;     tag = "R7"; end
        else         begin off = p / 2; tag = "R6"; end
        chk(nb == W, {tag, " bit count"}, nb, W);
        ew = '0;
        for (int i = 0; i < W; i++) begin
            ei = g0 + 2 + i * p + off;
            ew[W-1-i] = pat(ei - 2);
            if (i < nb) begin
                chk(got_e[i] == ei, {tag, " sample edge"}, got_e[i] - g0, ei - g0);
                chk(got_b[i] == pat(ei - 2), "R4 sampled value", int'(got_b[i]), int'(pat(ei - 2)));
            end
        end
        chk(nw == 1, "R9 word count", nw, 1);
        chk(word_e == g0 + 2 + (W - 1) * p + off, "R9 word edge",
            word_e - g0, 2 + (W - 1) * p + off);
        chk(word_v == ew, "R9 word value", int'(word_v), int'(ew));
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL R9 watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk(ctl_rdata == 32'h0, "R1 reset mode", int'(ctl_rdata), 0);
        chk(rx_bit_vld == 1'b0, "R1 reset bit valid", int'(rx_bit_vld), 0);
        chk(rx_word_vld == 1'b0, "R1 reset word valid", int'(rx_word_vld), 0);

        // R2 only the two mode bits are kept
        tick(1'b0, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF);
        chk(ctl_rdata == 32'h0000_2800, "R2 masked write", int'(ctl_rdata), 32'h2800);

        // vector table
        for (int v = 0; v < 8; v++) run_word(VECS[v].d, VECS[v].f, int'(VECS[v].p));

        // R3 write during transfer is held until busy falls
        set_mode(1'b0, 1'b1);
        tick(1'b0, 1'b0, 1'b1, 1'b0, '0);
        tick(1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_2000);
        chk(ctl_rdata == 32'h0000_0800, "R3 held during busy", int'(ctl_rdata), 32'h0800);
        tick(1'b0, 1'b0, 1'b1, 1'b0, '0);
        chk(ctl_rdata == 32'h0000_0800, "R3 still held", int'(ctl_rdata), 32'h0800);
        tick(1'b0, 1'b0, 1'b0, 1'b0, '0);
        chk(ctl_rdata == 32'h0000_2000, "R3 applied after busy", int'(ctl_rdata), 32'h2000);

        // R6 launch strobes with nothing pending take nothing
        set_mode(1'b0, 1'b0);
        nb = 0;
        for (int i = 0; i < 4; i++) begin
            tick(1'b0, 1'b1, 1'b1, 1'b0, '0);
            tick(1'b0, 1'b0, 1'b1, 1'b0, '0);
        end
        idle(2);
        chk(nb == 0, "R6 lone launch strobes", nb, 0);

        // R10 abort mid-word, then strobes while idle, then a clean word
        set_mode(1'b1, 1'b0);
        nb = 0; nw = 0;
        for (int i = 0; i < 3; i++) begin
            tick(1'b1, 1'b0, 1'b1, 1'b0, '0);
            tick(1'b0, 1'b0, 1'b1, 1'b0, '0);
        end
        chk(nb == 3, "R10 partial bits taken", nb, 3);
        tick(1'b1, 1'b0, 1'b0, 1'b0, '0);
        chk(rx_bit_vld == 1'b0, "R10 no sample while idle", int'(rx_bit_vld), 0);
        idle(2);
        chk(nw == 0, "R10 no word from abort", nw, 0);
        run_word(1'b1, 1'b0, 4);
        run_word(1'b0, 1'b1, 8);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule